// File: doc/BRIEF.md
# Prescaled Free-Running Time Base

This block is a 16-bit up counter that acts as the common time reference for neighbouring compare and capture channels. The counter runs continuously. Its live value is driven on a dedicated output bus so that other units can sample it in any cycle. A programmable prescaler derives the count rate from the system clock. It produces a one-cycle advance pulse every 4, 16, 32 or 64 clocks.

Software controls the block through a small word-wide register port. Writes take effect at the clock edge. Reads are combinational. Through this port software can:
- start and stop counting;
- choose the division;
- clear the count or load a new count;
- program compare register 0.

When auto-clear is enabled, the counter returns to zero on the step that finds it equal to compare register 0, which makes it a programmable-period timer. Two sticky event flags record a wrap past the top of the range and a compare-0 hit. Each flag has its own enable into a single level-sensitive interrupt output.

Top module: `tbase_counter`

## Requirements
- R1: After reset the count is 0x0000, the control word reads 0x0000 (division by 4, stopped, all enables and flags clear), compare register 0 reads 0xFFFF and irq_o is low.
- R2: While the run bit (control bit 2) is 1, the count advances by one once every D clock cycles. D is 4, 16, 32 or 64 for a division field (control bits 1:0) of 0, 1, 2 or 3. The count wraps from 0xFFFF to 0x0000.
- R3: A control write that changes the division field, or that requests a software clear, restarts the prescaler. The first advance after that write edge comes exactly D cycles later.
- R4: A control write with bit 8 set forces the count to 0x0000 at that edge. It takes priority over any advance in the same cycle, and that advance raises no flag. Bit 8 always reads 0.
- R5: On an advance that finds the count equal to compare register 0, the compare flag (control bit 7) is set. If auto-clear (control bit 3) is 1, the count becomes 0x0000 instead of count+1, and no overflow flag is raised, even when compare register 0 is 0xFFFF.
- R6: An advance that takes the count from 0xFFFF to 0x0000 by incrementing sets the overflow flag (control bit 6).
- R7: Both flags are sticky. A control write with a 0 in a flag's bit clears it, and a 1 leaves it unchanged. A flag event in the same cycle as a clearing write leaves the flag set.
- R8: irq_o is high exactly when (overflow flag and control bit 4) or (compare flag and control bit 5).
- R9: While the run bit is 0, the count and the prescaler phase hold their values.
- R10: Read address 0 returns the control word, 1 returns compare register 0, 2 returns the live count and 3 returns zero. A write to address 2 loads the count and overrides an advance in that cycle without raising a flag. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data, combinational from rd_addr |
| count_o | output | 16 | Live counter value for neighbouring units |
| irq_o | output | 1 | Level interrupt request |

## Verification
A prescaler phase error shows on count_o within one division period. The first advance after a restart arrives early or late, and from then on every step is offset. A wrong comparison or wrap decision shows in the cycle after the offending advance: either the count jumps to an unexpected value or a flag bit in the control word differs. A fault in flag retention or flag clearing can stay hidden until a later read of the control word or a change on irq_o. For this reason the bench compares count_o, irq_o and the read port against a reference model in every cycle.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  localparam int PRE_W = 6;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CMP  = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam logic [1:0] A_RSVD = 2'd3;

  localparam int B_RUN  = 2;
  localparam int B_MCLR = 3;
  localparam int B_OIE  = 4;
  localparam int B_CIE  = 5;
  localparam int B_OFL  = 6;
  localparam int B_CFL  = 7;
  localparam int B_SCLR = 8;

  typedef enum logic [1:0] {
    DIV_4  = 2'd0,
    DIV_16 = 2'd1,
    DIV_32 = 2'd2,
    DIV_64 = 2'd3
  } div_sel_e;

  typedef struct packed {
    logic     cmp_ie;
    logic     ovf_ie;
    logic     mclr;
    logic     run;
    div_sel_e div;
  } ctrl_t;

  function automatic int unsigned div_log2(div_sel_e s);
    case (s)
      DIV_4:   return 2;
      DIV_16:  return 4;
      DIV_32:  return 5;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
  import tbase_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     restart,
  input  div_sel_e div,
  output logic     tick
);

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_d;
  logic [PW-1:0] mask;
  logic          ph_en;

  always_comb begin
    mask = ~({PW{1'b1}} << div_log2(div));
    tick = run && ((ph_q & mask) == mask);
  end

  always_comb begin
    ph_en = restart | run;
    if (restart)   ph_d = '0;
    else if (tick) ph_d = '0;
    else           ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end

endmodule

// File: rtl/tbase_count_core.sv
module tbase_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sw_clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             mclr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             cmp_evt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             step_ok;
  logic             hit;
  logic             wrap_clr;
  logic             cnt_en;

  always_comb begin
    step_ok  = tick & ~sw_clr & ~load;
    hit      = (cnt_q == cmp_val);
    cmp_evt  = step_ok & hit;
    wrap_clr = cmp_evt & mclr;
    ovf_evt  = step_ok & ~wrap_clr & (&cnt_q);
    cnt_en   = sw_clr | load | step_ok;
    if (sw_clr)        cnt_d = '0;
    else if (load)     cnt_d = load_val;
    else if (wrap_clr) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tbase_ctrl_regs.sv
module tbase_ctrl_regs
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ovf_evt,
  input  logic             cmp_evt,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] cmp_val,
  output logic [1:0]       flags,
  output logic             sw_clr,
  output logic             restart,
  output logic             load
);

  localparam int NFLAG = 2;

  ctrl_t            ctrl_q;
  ctrl_t            ctrl_d;
  logic [CNT_W-1:0] cmp_q;
  logic             ctrl_wr;
  logic             cmp_wr;
  logic             div_chg;
  logic [NFLAG-1:0] evt_v;

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == A_CTRL);
    cmp_wr  = wr_en && (wr_addr == A_CMP);
    load    = wr_en && (wr_addr == A_CNT);
    sw_clr  = ctrl_wr & wr_data[B_SCLR];
    div_chg = ctrl_wr && (wr_data[1:0] != ctrl_q.div);
    restart = sw_clr | div_chg;
    ctrl_d.div    = div_sel_e'(wr_data[1:0]);
    ctrl_d.run    = wr_data[B_RUN];
    ctrl_d.mclr   = wr_data[B_MCLR];
    ctrl_d.ovf_ie = wr_data[B_OIE];
    ctrl_d.cmp_ie = wr_data[B_CIE];
    evt_v = {cmp_evt, ovf_evt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '1;
    else if (cmp_wr) cmp_q <= wr_data;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    localparam int BP = (g == 0) ? B_OFL : B_CFL;
    logic fl_q;
    logic fl_d;
    logic fl_en;
    always_comb begin
      fl_en = evt_v[g] | ctrl_wr;
      fl_d  = evt_v[g] | wr_data[BP];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     fl_q <= 1'b0;
      else if (fl_en) fl_q <= fl_d & (fl_q | evt_v[g]);
    end
    assign flags[g] = fl_q;
  end

  assign ctrl    = ctrl_q;
  assign cmp_val = cmp_q;

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cmp_q;
  logic [1:0]       flag_q;
  logic             sw_clr;
  logic             restart;
  logic             load;
  logic             tick;
  logic             ovf_evt;
  logic             cmp_evt;
  logic [CNT_W-1:0] cnt;

  tbase_ctrl_regs #(.CNT_W(CNT_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ovf_evt (ovf_evt),
    .cmp_evt (cmp_evt),
    .ctrl    (ctrl_q),
    .cmp_val (cmp_q),
    .flags   (flag_q),
    .sw_clr  (sw_clr),
    .restart (restart),
    .load    (load)
  );

  tbase_prescaler #(.PW(PRE_W)) pre_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .restart (restart),
    .div     (ctrl_q.div),
    .tick    (tick)
  );

  tbase_count_core #(.CNT_W(CNT_W)) core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .sw_clr   (sw_clr),
    .load     (load),
    .load_val (wr_data),
    .cmp_val  (cmp_q),
    .mclr     (ctrl_q.mclr),
    .cnt      (cnt),
    .ovf_evt  (ovf_evt),
    .cmp_evt  (cmp_evt)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[1:0]   = ctrl_q.div;
        rd_data[B_RUN] = ctrl_q.run;
        rd_data[B_MCLR]= ctrl_q.mclr;
        rd_data[B_OIE] = ctrl_q.ovf_ie;
        rd_data[B_CIE] = ctrl_q.cmp_ie;
        rd_data[B_OFL] = flag_q[0];
        rd_data[B_CFL] = flag_q[1];
      end
      A_CMP:   rd_data = cmp_q;
      A_CNT:   rd_data = cnt;
      default: rd_data = '0;
    endcase
  end

  assign count_o = cnt;
  assign irq_o   = (flag_q[0] & ctrl_q.ovf_ie) | (flag_q[1] & ctrl_q.cmp_ie);

endmodule

// File: rtl/tbase_counter_chk.sv
module tbase_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_flag,
  input logic             cmp_flag,
  input logic [CNT_W-1:0] cmp_val,
  input logic             run
);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data[8]) |=> (count_o == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(count_o));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (count_o == $past(count_o) ||
                count_o == CNT_W'($past(count_o) + 1'b1) ||
                count_o == '0));

  assert_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(count_o) == '1 && count_o == '0));

  assert_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> ($past(count_o) == $past(cmp_val)));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(wr_en && wr_addr == 2'd0 && !wr_data[6]));

endmodule

bind tbase_counter tbase_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .count_o  (count_o),
  .ovf_flag (flag_q[0]),
  .cmp_flag (flag_q[1]),
  .cmp_val  (cmp_q),
  .run      (ctrl_q.run)
);

// File: tb/tbase_counter_tb.sv
module tbase_counter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [15:0] count_o;
  logic        irq_o;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tbase_counter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .count_o(count_o), .irq_o(irq_o)
  );

  // reference model state, written from the requirements
  logic [15:0] m_cnt, m_cmp;
  logic [6:0]  m_pre;
  logic [1:0]  m_div;
  logic        m_run, m_mclr, m_oie, m_cie, m_of, m_cf;

  function automatic int dval(logic [1:0] s);
    case (s)
      2'd0: return 4;
      2'd1: return 16;
      2'd2: return 32;
      default: return 64;
    endcase
  endfunction

  function automatic logic [15:0] m_ctrl();
    return {8'h00, m_cf, m_of, m_cie, m_oie, m_mclr, m_run, m_div};
  endfunction

  function automatic logic [15:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_ctrl();
      2'd1: return m_cmp;
      2'd2: return m_cnt;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic m_irq();
    return (m_of & m_oie) | (m_cf & m_cie);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_cmp = 16'hFFFF; m_pre = '0; m_div = '0;
      m_run = 0; m_mclr = 0; m_oie = 0; m_cie = 0; m_of = 0; m_cf = 0;
    end else begin
      logic cw, sw, rs, ld, tk, step, hit, oe, ce;
      cw = wr_en && wr_addr == 2'd0;
      sw = cw && wr_data[8];
      rs = sw || (cw && wr_data[1:0] != m_div);
      ld = wr_en && wr_addr == 2'd2;
      tk = m_run && (int'(m_pre) == dval(m_div) - 1);
      step = tk && !sw && !ld;
      hit = (m_cnt == m_cmp);
      ce = step && hit;
      oe = step && !(hit && m_mclr) && m_cnt == 16'hFFFF;
      if (sw) m_cnt = '0;
      else if (ld) m_cnt = wr_data;
      else if (step) m_cnt = (hit && m_mclr) ? 16'h0000 : m_cnt + 16'd1;
      if (rs) m_pre = '0;
      else if (m_run) m_pre = tk ? '0 : m_pre + 7'd1;
      m_of = oe ? 1'b1 : (cw && !wr_data[6]) ? 1'b0 : m_of;
      m_cf = ce ? 1'b1 : (cw && !wr_data[7]) ? 1'b0 : m_cf;
      if (cw) begin
        m_div = wr_data[1:0]; m_run = wr_data[2]; m_mclr = wr_data[3];
        m_oie = wr_data[4]; m_cie = wr_data[5];
      end
      if (wr_en && wr_addr == 2'd1) m_cmp = wr_data;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model, mid low phase
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk("R2 count", count_o, m_cnt);
      chk("R8 irq", {15'd0, irq_o}, {15'd0, m_irq()});
      chk("R10 read", rd_data, m_read(rd_addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  logic [15:0] v;

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count_o, 16'h0000);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); chk("R1 cmp", v, 16'hFFFF);
    // R3 restart on division change, /16
    wr(2'd0, 16'h0005);
    idle(15); chk("R3 before", count_o, 16'h0000);
    idle(1);  chk("R3 first step", count_o, 16'h0001);
    // R9 stop holds
    wr(2'd0, 16'h0001);
    v = count_o;
    idle(100); chk("R9 hold", count_o, v);
    // R4 software clear
    wr(2'd0, 16'h0104);
    chk("R4 clear", count_o, 16'h0000);
    rd(2'd0, v); chk("R4 bit8 reads 0", v, 16'h0004);
    // R5 auto-clear at compare 3
    wr(2'd1, 16'h0003);
    wr(2'd0, 16'h012C);
    idle(12); chk("R5 at cmp", count_o, 16'h0003);
    idle(4);  chk("R5 clear", count_o, 16'h0000);
    chk("R8 cmp irq", {15'd0, irq_o}, 16'd1);
    // R7 write 1 keeps, write 0 clears
    wr(2'd0, 16'h00AC);
    rd(2'd0, v); chk("R7 keep", v & 16'h0080, 16'h0080);
    wr(2'd0, 16'h0028);
    rd(2'd0, v); chk("R7 cleared", v, 16'h0028);
    chk("R7 irq low", {15'd0, irq_o}, 16'd0);
    // R6 overflow
    wr(2'd0, 16'h0011);
    wr(2'd2, 16'hFFFE);
    wr(2'd0, 16'h0014);
    idle(4); chk("R6 top", count_o, 16'hFFFF);
    idle(4); chk("R6 wrap", count_o, 16'h0000);
    rd(2'd0, v); chk("R6 flag", v, 16'h0054);
    chk("R8 ovf irq", {15'd0, irq_o}, 16'd1);
    // R5 compare at 0xFFFF with auto-clear: no overflow flag
    wr(2'd1, 16'hFFFF);
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'hFFFF);
    wr(2'd0, 16'h000C);
    idle(4); chk("R5 top clear", count_o, 16'h0000);
    rd(2'd0, v); chk("R5 flags", v, 16'h008C);
    chk("R8 no enable", {15'd0, irq_o}, 16'd0);
    // R2 division by 64
    wr(2'd0, 16'h0107);
    idle(63); chk("R2 d64 before", count_o, 16'h0000);
    idle(1);  chk("R2 d64 step", count_o, 16'h0001);
    // R10 reserved address
    wr(2'd3, 16'hBEEF);
    rd(2'd3, v); chk("R10 rsvd", v, 16'h0000);
    rd(2'd1, v); chk("R10 cmp kept", v, 16'hFFFF);
    // constrained random phase
    for (int i = 0; i < 30000; i++) begin
      int r;
      r = $urandom % 100;
      rd_addr = 2'($urandom % 4);
      if (r < 3)
        wr(2'd0, 16'($urandom & 32'h00FF) | (($urandom % 8 == 0) ? 16'h0100 : 16'h0000));
      else if (r < 5)
        wr(2'd1, ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom % 64));
      else if (r < 6)
        wr(2'd2, ($urandom % 2 == 0) ? 16'(16'hFFF0 + $urandom % 16) : 16'($urandom));
      else if (r < 7)
        wr(2'd3, 16'($urandom));
      else
        @(negedge clk);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule